// File: doc/BRIEF.md
# Fixed-Level Trap Arbiter

This block gathers fault strobes from the processor and memory system and turns them into trap requests that cannot be masked. Faults are grouped into four trap classes, each with a fixed priority level between 11 and 14, above every user interrupt level. Every fault cause has its own sticky status bit. A trap class is pending while any of its cause bits is set.

The arbiter always presents the highest pending class. It gives the class's level and vector index, and flags the trap as hard (the processor must take it at once) or soft (the current instruction may complete first). Software clears individual cause bits with a write-one-to-clear vector. When a class is cleared, the next pending class is presented. The block has no mask input and no disable input, so no instruction or setting can suppress a trap.

Top module: `trap_arbiter`

## Requirements
- R1: While reset is low at a clock edge, all status bits, `trap_req`, `trap_level`, `trap_vector` and `trap_hard` become zero.
- R2: A strobe that is high at a clock edge sets its status bit at that edge. The bits of `cause_status` are: 0 divide by zero, 1 unsaturated accumulator overflow, 2 catastrophic accumulator overflow, 3 accumulator shift overflow, 4 stack overflow, 5 stack underflow, 6 illegal program-space fetch, 7 unimplemented data-space fetch, 8 unaligned data word access, 9 oscillator failure.
- R3: A status bit stays set until its `cause_clr` bit is high at an edge. When a clear and a strobe hit the same bit at the same edge, the strobe wins.
- R4: `trap_req` is high exactly when at least one status bit is set, and it follows the status in the same cycle.
- R5: The classes have these levels: oscillator (bit 9) level 14, address (bits 6 to 8) level 13, stack (bits 4 to 5) level 12, math (bits 0 to 3) level 11. `trap_level` is the level of the highest pending class, or 0 when none is pending.
- R6: `trap_vector` is 1 for oscillator, 2 for address, 3 for stack and 4 for math, and 0 when no trap is pending.
- R7: `trap_hard` is 1 when the presented level is 13 or 14, and 0 for levels 11 and 12 or when nothing is pending.
- R8: A lower class that is pending together with a higher one stays pending. Once the higher class is cleared, the lower one is presented.
- R9: A class with several set causes stays pending until every one of its cause bits is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_math | input | 4 | Math fault strobes (status bits 0 to 3) |
| flt_stack | input | 2 | Stack overflow / underflow strobes (bits 4 to 5) |
| flt_addr | input | 3 | Address fault strobes (bits 6 to 8) |
| flt_osc_fail | input | 1 | Oscillator failure strobe (bit 9) |
| cause_clr | input | 10 | Write-one-to-clear per status bit |
| trap_req | output | 1 | A trap is pending |
| trap_level | output | 4 | Level of the presented trap, 0 if none |
| trap_vector | output | 3 | Vector index of the presented trap, 0 if none |
| trap_hard | output | 1 | Presented trap is hard |
| cause_status | output | 10 | Sticky cause bits |

## Verification
Every state bit is visible on `cause_status`, so a lost or stuck latch shows up at the ports one edge after the strobe or clear that should have changed it. A wrong priority or mapping needs no extra state to show itself. Because the outputs are combinational from the latches, it appears as a wrong level, vector or hard flag in the same cycle as the status pattern. The sweep walks every one of the 1024 status patterns. For each one it also checks partial clears and the case where a strobe and a clear collide, so a fault in any class boundary is seen within a few cycles of that pattern being applied.

// File: rtl/trap_pkg.sv
// Shared constants for the trap arbiter.
// Classes are numbered from lowest level (0) to highest level (NUM_CLASSES-1).
// Cause bits of class c start at cause_offset(c).
package trap_pkg;
    localparam int unsigned NUM_CLASSES = 4;
    // cause counts per class: math, stack, address, oscillator
    localparam int unsigned CLS_WIDTH [NUM_CLASSES] = '{4, 2, 3, 1};
    localparam int unsigned LEVEL_BASE     = 11;
    localparam int unsigned HARD_LEVEL_MIN = 13;
    localparam int unsigned LVL_W = 4;
    localparam int unsigned VEC_W = $clog2(NUM_CLASSES + 1);
    localparam int unsigned IDX_W = $clog2(NUM_CLASSES);

    // first cause bit of a class
    function automatic int unsigned cause_offset(input int unsigned cls);
        int unsigned s;
        s = 0;
        for (int unsigned k = 0; k < cls; k++) s += CLS_WIDTH[k];
        return s;
    endfunction

    localparam int unsigned NUM_CAUSES = cause_offset(NUM_CLASSES);
endpackage

// File: rtl/trap_cause_latch.sv
// Sticky latch for the cause bits of one trap class.
// Assumes: set has priority over clear on the same bit; synchronous active-low reset.
module trap_cause_latch #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o,
    output logic         any_o
);
    logic [W-1:0] q_r;

    // hold set bits, drop cleared ones, new strobes always land
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= (q_r & ~clr_i) | set_i;
    end

    // class pending when any cause is held
    always_comb begin
        q_o   = q_r;
        any_o = |q_r;
    end
endmodule

// File: rtl/trap_prio_sel.sv
// Fixed-priority selector: the highest-numbered pending input wins.
// Assumes: N >= 2; output index is meaningless when valid_o is low (driven 0).
module trap_prio_sel #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // scan upward so the last (highest) pending entry is kept
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int unsigned i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/trap_arbiter.sv
// Trap arbiter top: latches fault causes per class and presents the
// highest pending class with its level, vector index and hard/soft flag.
// Assumes: strobes are synchronous to clk; there is no mask of any kind.
module trap_arbiter
    import trap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            flt_math,
    input  logic [1:0]            flt_stack,
    input  logic [2:0]            flt_addr,
    input  logic                  flt_osc_fail,
    input  logic [NUM_CAUSES-1:0] cause_clr,
    output logic                  trap_req,
    output logic [LVL_W-1:0]      trap_level,
    output logic [VEC_W-1:0]      trap_vector,
    output logic                  trap_hard,
    output logic [NUM_CAUSES-1:0] cause_status
);
    logic [NUM_CAUSES-1:0]  cause_in;
    logic [NUM_CLASSES-1:0] cls_pend;
    logic                   sel_valid;
    logic [IDX_W-1:0]       sel_idx;

    // gather strobes in status-bit order
    always_comb cause_in = {flt_osc_fail, flt_addr, flt_stack, flt_math};

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        localparam int unsigned LO = cause_offset(c);
        localparam int unsigned W  = CLS_WIDTH[c];
        trap_cause_latch #(.W(W)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (cause_in[LO +: W]),
            .clr_i (cause_clr[LO +: W]),
            .q_o   (cause_status[LO +: W]),
            .any_o (cls_pend[c])
        );
    end

    trap_prio_sel #(.N(NUM_CLASSES)) u_sel (
        .pend_i  (cls_pend),
        .valid_o (sel_valid),
        .idx_o   (sel_idx)
    );

    // map winning class to level, vector and hard flag
    always_comb begin
        trap_req    = sel_valid;
        trap_level  = '0;
        trap_vector = '0;
        trap_hard   = 1'b0;
        if (sel_valid) begin
            trap_level  = LVL_W'(LEVEL_BASE + int'(sel_idx));
            trap_vector = VEC_W'(NUM_CLASSES - int'(sel_idx));
            trap_hard   = (LEVEL_BASE + int'(sel_idx)) >= HARD_LEVEL_MIN;
        end
    end
endmodule

// File: rtl/trap_arbiter_chk.sv
// Assertion checker for trap_arbiter, attached with bind.
// Assumes the port names of trap_arbiter.
module trap_arbiter_chk
    import trap_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [3:0]            flt_math,
    input logic [1:0]            flt_stack,
    input logic [2:0]            flt_addr,
    input logic                  flt_osc_fail,
    input logic [NUM_CAUSES-1:0] cause_clr,
    input logic                  trap_req,
    input logic [LVL_W-1:0]      trap_level,
    input logic [VEC_W-1:0]      trap_vector,
    input logic                  trap_hard,
    input logic [NUM_CAUSES-1:0] cause_status
);
    logic [NUM_CAUSES-1:0] strb;
    always_comb strb = {flt_osc_fail, flt_addr, flt_stack, flt_math};

    // R2
    strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_status & $past(strb)) == $past(strb)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_status & $past(cause_status & ~cause_clr)) == $past(cause_status & ~cause_clr)));

    // R3
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_status & $past(cause_clr & ~strb)) == '0));

    // R4
    req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req == (cause_status != '0));

    // R5
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_level >= 4'd11 && trap_level <= 4'd14));

    // R5
    osc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_status[NUM_CAUSES-1] |-> (trap_level == 4'd14));

    // R6
    vector_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((5'(trap_level) + 5'(trap_vector)) == 5'd15));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_level == '0 && trap_vector == '0 && !trap_hard));

    // R7
    hard_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_hard == (trap_level >= 4'd13)));
endmodule

bind trap_arbiter trap_arbiter_chk u_chk (.*);

// File: tb/trap_arbiter_bench.sv
`timescale 1ns/1ps
module trap_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] flt_math = '0;
    logic [1:0] flt_stack = '0;
    logic [2:0] flt_addr = '0;
    logic       flt_osc_fail = 1'b0;
    logic [9:0] cause_clr = '0;
    logic       trap_req;
    logic [3:0] trap_level;
    logic [2:0] trap_vector;
    logic       trap_hard;
    logic [9:0] cause_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    trap_arbiter u_trap_arbiter (.*);

    // expected {req, level, vector, hard, status} from a status pattern
    function automatic logic [18:0] expect_of(input logic [9:0] s);
        int cls;
        logic [3:0] lvl;
        logic [2:0] vec;
        cls = -1;
        if (|s[3:0]) cls = 0;
        if (|s[5:4]) cls = 1;
        if (|s[8:6]) cls = 2;
        if (s[9])    cls = 3;
        if (cls < 0) return {9'd0, s};
        lvl = 4'(11 + cls);
        vec = 3'(4 - cls);
        return {1'b1, lvl, vec, (lvl >= 4'd13), s};
    endfunction

    task automatic chk(input string req, input logic [18:0] exp);
        logic [18:0] got;
        got = {trap_req, trap_level, trap_vector, trap_hard, cause_status};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // drive for one edge, then return at the following falling edge
    task automatic step(input logic [9:0] strobe, input logic [9:0] clr);
        {flt_osc_fail, flt_addr, flt_stack, flt_math} = strobe;
        cause_clr = clr;
        @(negedge clk);
        {flt_osc_fail, flt_addr, flt_stack, flt_math} = '0;
        cause_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 19'd0);

        // full sweep over every status pattern
        for (int p = 0; p < 1024; p++) begin
            logic [9:0] pat;
            pat = 10'(p);
            step(pat, 10'h000);
            chk("R2/R4/R5/R6/R7 capture", expect_of(pat));
            step(10'h000, 10'h3C0);
            chk("R3/R8 partial clear", expect_of(pat & 10'h03F));
            step(10'h001, 10'h3FF);
            chk("R3 strobe beats clear", expect_of(10'h001));
            step(10'h000, 10'h3FF);
            chk("R3 full clear", expect_of(10'h000));
        end

        // R9: two address causes, cleared one at a time
        step(10'h0C0, 10'h000);
        chk("R9 two causes", expect_of(10'h0C0));
        step(10'h000, 10'h040);
        chk("R9 one cause left", expect_of(10'h080));
        step(10'h000, 10'h080);
        chk("R9 class drained", expect_of(10'h000));

        // R8: oscillator plus math, drop oscillator
        step(10'h201, 10'h000);
        chk("R8 higher shown", expect_of(10'h201));
        step(10'h000, 10'h200);
        chk("R8 lower now shown", expect_of(10'h001));
        step(10'h000, 10'h3FF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule